// File: doc/BRIEF.md
# NAND Page Hamming ECC Generator

This block computes a single-error-correcting Hamming code over NAND page data while the bytes stream past between the system bus and the flash device. The page is split into 256-byte chunks. Every data bit in a chunk has an 11-bit position: the byte index in the chunk forms the upper 8 bits and the bit number inside the byte forms the lower 3 bits. For each address bit, the generator keeps two parities. One covers the data bits whose position has that bit set. The other covers the data bits whose position has that bit clear. A corrector that compares a stored code with a freshly computed one can find a single flipped bit from the XOR of the two.

Software clears the generator before each page transfer. It then streams 256 or 512 bytes through it, selected by the page-size input, and reads the codes once the chunks are done. A second 256-byte chunk, used only in 512-byte mode, has its own code in its own register pair. For storage in the spare area, each chunk's two words are packed as a 22-bit value: the set-bit word sits in the low 11 bits and the clear-bit word in the high 11 bits. That value is written as three bytes, least significant byte first. Packing, storing and correcting are handled outside this block.

Top module: `nand_hamming_ecc`

## Requirements
- R1: After reset, all four code outputs and `chunk_done_o` are zero.
- R2: For a chunk, bit k of the set-bit word is the XOR of every data bit whose position {byte index[7:0], bit number[2:0]} has bit k equal to 1. Bit k of the clear-bit word is the XOR of every data bit whose position has bit k equal to 0.
- R3: The clock edge that accepts the 256th byte of the first chunk loads that chunk's set-bit word into `ecc0_o` and its clear-bit word into `ecc1_o`. `chunk_done_o` is high for exactly the one following cycle.
- R4: In 512-byte mode (`page512_i`=1), bytes 256 to 511 form a separate code that starts from zero. It goes to `ecc2_o` (set-bit word) and `ecc3_o` (clear-bit word) on the edge that accepts byte 511.
- R5: A cycle with `byte_vld_i` low does not change the code state or the byte count, so gaps in the stream leave the result unchanged.
- R6: Once 256 bytes (`page512_i`=0) or 512 bytes (`page512_i`=1) have been accepted since the last clear, further valid bytes are ignored: no output changes and `chunk_done_o` stays low.
- R7: A cycle with `clr_i` high zeroes the byte count, the accumulator, all four code outputs and `chunk_done_o` from the next cycle.
- R8: A byte presented in the same cycle as `clr_i` is discarded; the first byte after the clear is byte 0.
- R9: The code outputs hold their values between a chunk completion and the next completion or clear.
- R10: At every cycle, the XOR of the two words of a chunk is either all zeros or all ones, because each data bit lands in exactly one word of each pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of count, accumulator and codes |
| page512_i | input | 1 | 1: 512-byte page (two chunks); 0: 256-byte page |
| byte_vld_i | input | 1 | Data byte is valid this cycle |
| byte_i | input | 8 | Data byte |
| ecc0_o | output | 11 | Chunk 0 set-bit word |
| ecc1_o | output | 11 | Chunk 0 clear-bit word |
| ecc2_o | output | 11 | Chunk 1 set-bit word |
| ecc3_o | output | 11 | Chunk 1 clear-bit word |
| chunk_done_o | output | 1 | One-cycle pulse after a chunk's code is loaded |

## Verification
The assertions check, on every cycle:
- the clear result;
- the single-cycle completion pulse;
- that the code outputs hold outside completions;
- that bytes past the page limit are dropped;
- that the two words of a chunk are complementary.

Whether the code values themselves are correct can only be shown by the bench's scenarios, which compare every output each cycle against a model that sums bit positions. These scenarios cover:
- a single-bit chunk with a known expected pattern;
- random data with gaps in `byte_vld_i`;
- a full 512-byte page;
- a clear that collides with a valid byte.

// File: rtl/nhe_pkg.sv
package nhe_pkg;
  localparam int unsigned CHUNK_BYTES = 256;
  localparam int unsigned MAX_CHUNKS  = 2;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned BIT_IDX_W   = $clog2(BYTE_W);
  localparam int unsigned BYTE_IDX_W  = $clog2(CHUNK_BYTES);
  localparam int unsigned ECC_W       = BYTE_IDX_W + BIT_IDX_W;
  localparam int unsigned CHUNK_W     = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1;
  localparam int unsigned CNT_W       = $clog2(CHUNK_BYTES * MAX_CHUNKS) + 1;

  typedef logic [ECC_W-1:0] ecc_word_t;

  typedef struct packed {
    ecc_word_t ones;   // parity over positions with address bit set
    ecc_word_t zeros;  // parity over positions with address bit clear
  } ecc_pair_t;
endpackage

// File: rtl/nhe_byte_contrib.sv
module nhe_byte_contrib
  import nhe_pkg::*;
(
  input  logic [BYTE_W-1:0]     byte_i,
  input  logic [BYTE_IDX_W-1:0] idx_i,
  output ecc_pair_t             contrib_o
);
  logic [ECC_W-1:0] ones, zeros;
  logic             byte_par;

  assign byte_par = ^byte_i;

  // bit-in-byte address bits: fixed column masks
  for (genvar k = 0; k < BIT_IDX_W; k++) begin : g_col
    logic [BYTE_W-1:0] col_mask;
    for (genvar j = 0; j < BYTE_W; j++) begin : g_bit
      localparam bit SET = ((j >> k) & 1) == 1;
      assign col_mask[j] = SET;
    end
    assign ones[k]  = ^(byte_i & col_mask);
    assign zeros[k] = ^(byte_i & ~col_mask);
  end

  // byte-index address bits: whole-byte parity steered by index
  for (genvar k = 0; k < BYTE_IDX_W; k++) begin : g_row
    assign ones[BIT_IDX_W+k]  = idx_i[k] & byte_par;
    assign zeros[BIT_IDX_W+k] = ~idx_i[k] & byte_par;
  end

  assign contrib_o = '{ones: ones, zeros: zeros};
endmodule

// File: rtl/nhe_byte_seq.sv
module nhe_byte_seq
  import nhe_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  vld_i,
  input  logic                  page512_i,
  output logic                  accept_o,
  output logic                  last_o,
  output logic [CHUNK_W-1:0]    chunk_o,
  output logic [BYTE_IDX_W-1:0] idx_o
);
  localparam logic [CNT_W-1:0] LIM_SMALL = CNT_W'(CHUNK_BYTES);
  localparam logic [CNT_W-1:0] LIM_FULL  = CNT_W'(CHUNK_BYTES * MAX_CHUNKS);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit    = page512_i ? LIM_FULL : LIM_SMALL;
  assign accept_o = vld_i && !clr_i && (cnt_q < limit);
  assign idx_o    = cnt_q[BYTE_IDX_W-1:0];
  assign chunk_o  = cnt_q[BYTE_IDX_W +: CHUNK_W];
  assign last_o   = accept_o && (idx_o == {BYTE_IDX_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (accept_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/nhe_chunk_acc.sv
module nhe_chunk_acc
  import nhe_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      upd_i,
  input  logic      wrap_i,
  input  ecc_pair_t contrib_i,
  output ecc_pair_t sum_o
);
  ecc_pair_t acc_q;

  assign sum_o = acc_q ^ contrib_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (upd_i)  acc_q <= wrap_i ? '0 : sum_o;
  end
endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc
  import nhe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              page512_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [ECC_W-1:0]  ecc0_o,
  output logic [ECC_W-1:0]  ecc1_o,
  output logic [ECC_W-1:0]  ecc2_o,
  output logic [ECC_W-1:0]  ecc3_o,
  output logic              chunk_done_o
);
  logic                  accept, last;
  logic [CHUNK_W-1:0]    chunk;
  logic [BYTE_IDX_W-1:0] idx;
  ecc_pair_t             contrib, sum;
  ecc_pair_t             bank_q [MAX_CHUNKS];
  logic                  done_q;

  nhe_byte_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .vld_i     (byte_vld_i),
    .page512_i (page512_i),
    .accept_o  (accept),
    .last_o    (last),
    .chunk_o   (chunk),
    .idx_o     (idx)
  );

  nhe_byte_contrib u_contrib (
    .byte_i    (byte_i),
    .idx_i     (idx),
    .contrib_o (contrib)
  );

  nhe_chunk_acc u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .upd_i     (accept),
    .wrap_i    (last),
    .contrib_i (contrib),
    .sum_o     (sum)
  );

  for (genvar c = 0; c < MAX_CHUNKS; c++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                bank_q[c] <= '0;
      else if (clr_i)                             bank_q[c] <= '0;
      else if (last && (chunk == CHUNK_W'(c)))    bank_q[c] <= sum;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= last;
  end

  assign ecc0_o       = bank_q[0].ones;
  assign ecc1_o       = bank_q[0].zeros;
  assign ecc2_o       = bank_q[MAX_CHUNKS-1].ones;
  assign ecc3_o       = bank_q[MAX_CHUNKS-1].zeros;
  assign chunk_done_o = done_q;
endmodule

// File: rtl/nhe_checker.sv
module nhe_checker
  import nhe_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_i,
  input logic              page512_i,
  input logic              byte_vld_i,
  input logic [BYTE_W-1:0] byte_i,
  input logic [ECC_W-1:0]  ecc0_o,
  input logic [ECC_W-1:0]  ecc1_o,
  input logic [ECC_W-1:0]  ecc2_o,
  input logic [ECC_W-1:0]  ecc3_o,
  input logic              chunk_done_o
);
  logic [CNT_W-1:0] seen_q;
  logic [CNT_W-1:0] lim;
  logic             room, closing;

  assign lim     = page512_i ? CNT_W'(CHUNK_BYTES * MAX_CHUNKS) : CNT_W'(CHUNK_BYTES);
  assign room    = seen_q < lim;
  assign closing = byte_vld_i && !clr_i && room &&
                   ((seen_q % CNT_W'(CHUNK_BYTES)) == CNT_W'(CHUNK_BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           seen_q <= '0;
    else if (clr_i)                        seen_q <= '0;
    else if (byte_vld_i && room)           seen_q <= seen_q + 1'b1;
  end

  a_r3_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chunk_done_o |=> !chunk_done_o);

  a_r6_beyond_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && !clr_i && !room) |=>
      ($stable(ecc0_o) && $stable(ecc1_o) && $stable(ecc2_o) && $stable(ecc3_o) && !chunk_done_o));

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ecc0_o == '0 && ecc1_o == '0 && ecc2_o == '0 && ecc3_o == '0 && !chunk_done_o));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !closing) |=>
      ($stable(ecc0_o) && $stable(ecc1_o) && $stable(ecc2_o) && $stable(ecc3_o)));

  a_r10_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((ecc0_o ^ ecc1_o) == '0) || ((ecc0_o ^ ecc1_o) == '1)) &&
    (((ecc2_o ^ ecc3_o) == '0) || ((ecc2_o ^ ecc3_o) == '1)));
endmodule

bind nand_hamming_ecc nhe_checker u_nhe_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clr_i        (clr_i),
  .page512_i    (page512_i),
  .byte_vld_i   (byte_vld_i),
  .byte_i       (byte_i),
  .ecc0_o       (ecc0_o),
  .ecc1_o       (ecc1_o),
  .ecc2_o       (ecc2_o),
  .ecc3_o       (ecc3_o),
  .chunk_done_o (chunk_done_o)
);

// File: tb/tb_nand_hamming_ecc.sv
module tb_nand_hamming_ecc;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0, page512_i = 1'b0, byte_vld_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic [10:0] ecc0_o, ecc1_o, ecc2_o, ecc3_o;
  logic        chunk_done_o;

  always #4 clk = ~clk;  // 125 MHz

  nand_hamming_ecc dut (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr_i), .page512_i(page512_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .ecc0_o(ecc0_o), .ecc1_o(ecc1_o), .ecc2_o(ecc2_o), .ecc3_o(ecc3_o),
    .chunk_done_o(chunk_done_o)
  );

  int checks = 0, fails = 0;
  string tag = "R1";

  // behavioural reference
  int          m_cnt = 0;
  logic [10:0] m_w0 = '0, m_w1 = '0;
  logic [10:0] m_e [4] = '{default: '0};
  bit          m_done = 0;

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic compare();
    checks++;
    if (ecc0_o !== m_e[0] || ecc1_o !== m_e[1] || ecc2_o !== m_e[2] ||
        ecc3_o !== m_e[3] || chunk_done_o !== m_done) begin
      fails++;
      $display("FAIL %s: actual=%h %h %h %h d%b expected=%h %h %h %h d%b", tag,
               ecc0_o, ecc1_o, ecc2_o, ecc3_o, chunk_done_o,
               m_e[0], m_e[1], m_e[2], m_e[3], m_done);
    end
  endtask

  task automatic model_step(input bit v, input logic [7:0] d, input bit c, input bit p);
    int lim;
    m_done = 0;
    if (c) begin
      m_cnt = 0; m_w0 = '0; m_w1 = '0;
      foreach (m_e[i]) m_e[i] = '0;
      return;
    end
    lim = p ? 512 : 256;
    if (v && m_cnt < lim) begin
      for (int j = 0; j < 8; j++) begin
        if (d[j]) begin
          int pos = (m_cnt % 256) * 8 + j;
          for (int k = 0; k < 11; k++)
            if ((pos >> k) & 1) m_w0[k] = ~m_w0[k];
            else                m_w1[k] = ~m_w1[k];
        end
      end
      m_cnt++;
      if (m_cnt % 256 == 0) begin
        m_e[(m_cnt / 256 - 1) * 2]     = m_w0;
        m_e[(m_cnt / 256 - 1) * 2 + 1] = m_w1;
        m_w0 = '0; m_w1 = '0;
        m_done = 1;
      end
    end
  endtask

  task automatic cyc(input bit v, input logic [7:0] d, input bit c, input bit p);
    @(negedge clk);
    compare();
    byte_vld_i = v; byte_i = d; clr_i = c; page512_i = p;
    model_step(v, d, c, p);
  endtask

  task automatic idle(input bit p);
    cyc(1'b0, 8'h00, 1'b0, p);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : stim
    void'($urandom(7));
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("R1 reset ecc0", 32'(ecc0_o), 0);
    chk("R1 reset done", 32'(chunk_done_o), 0);
    rst_ni = 1'b1;

    // R2/R3: single set bit at byte 0x5A bit 3 -> position 0x2D3
    tag = "R2";
    for (int b = 0; b < 256; b++) cyc(1'b1, (b == 8'h5A) ? 8'h08 : 8'h00, 1'b0, 1'b0);
    idle(1'b0);
    chk("R2 single-bit ones word", 32'(ecc0_o), 32'h2D3);
    chk("R2 single-bit zeros word", 32'(ecc1_o), 32'h52C);
    chk("R3 done pulse", 32'(chunk_done_o), 1);
    idle(1'b0);
    chk("R3 done falls", 32'(chunk_done_o), 0);

    // R6: extra bytes in 256 mode ignored
    tag = "R6";
    for (int b = 0; b < 20; b++) cyc(1'b1, 8'(b * 37 + 1), 1'b0, 1'b0);
    idle(1'b0);
    chk("R6 ecc0 unchanged", 32'(ecc0_o), 32'h2D3);
    chk("R6 ecc2 untouched", 32'(ecc2_o), 0);

    // R7: clear
    tag = "R7";
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    idle(1'b0);
    chk("R7 ecc0 cleared", 32'(ecc0_o), 0);
    chk("R7 ecc1 cleared", 32'(ecc1_o), 0);

    // R2/R5: all-ones chunk gives zero words
    tag = "R2";
    for (int b = 0; b < 256; b++) cyc(1'b1, 8'hFF, 1'b0, 1'b0);
    idle(1'b0);
    chk("R2 all-ones ecc0", 32'(ecc0_o), 0);
    cyc(1'b0, 8'h00, 1'b1, 1'b1);

    // R4/R5: 512-byte page, random data with gaps
    tag = "R4";
    for (int n = 0; n < 520;) begin
      bit v = ($urandom_range(0, 3) != 0);
      cyc(v, 8'($urandom), 1'b0, 1'b1);
      if (v) n++;
    end
    repeat (3) idle(1'b1);
    tag = "R9";
    repeat (10) idle(1'b1);
    chk("R4 chunk1 ones", 32'(ecc2_o), 32'(m_e[2]));
    chk("R10 chunk1 complement", 32'((ecc2_o ^ ecc3_o) == 11'h7FF || (ecc2_o ^ ecc3_o) == 11'h0), 1);

    // R8: clear colliding with a byte
    tag = "R8";
    cyc(1'b1, 8'hFF, 1'b1, 1'b0);
    for (int b = 0; b < 255; b++) cyc(1'b1, 8'h00, 1'b0, 1'b0);
    idle(1'b0);
    chk("R8 no early done", 32'(chunk_done_o), 0);
    cyc(1'b1, 8'h01, 1'b0, 1'b0);
    idle(1'b0);
    chk("R8 byte255 bit0 ones", 32'(ecc0_o), 32'h7F8);
    chk("R8 done after 256", 32'(chunk_done_o), 1);

    // R5: random 256 chunk with sparse valid
    tag = "R5";
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    for (int n = 0; n < 256;) begin
      bit v = ($urandom_range(0, 1) != 0);
      cyc(v, 8'($urandom), 1'b0, 1'b0);
      if (v) n++;
    end
    repeat (4) idle(1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule